// File: doc/BRIEF.md
# Interrupt Line Router With Core And Pin Steering

This block steers 256 level-sensitive device interrupt lines onto a grid of per-core output pins: four cores with four pins each. Every line has an enable bit and a recorded input level. A steering byte in a pin table picks the pin for each group of 32 lines. A steering byte per line picks the target core. Each line also has one pending bit, which belongs to the core it is currently steered to. A core/pin output stays high while at least one pending line is steered to that pair.

Software reaches all state through one 64-bit word-addressed port: a write strobe, an address, write data, and a core selector. The core selector says which core's view of the pending register is read or cleared. The read data port is combinational on the address. A configuration word picks, for pins and for cores separately, whether a steering byte is decoded as a one-hot field or as a binary number. That word is masked by a fixed capability word. Once the controller-enable bit is set, the configuration is locked against nonzero writes. Changing a line's enable bit, or its target core, re-evaluates the line at once. This happens without waiting for a new input edge.

Top module: `irq_route_top`

## Requirements
- R1: After reset, every register reads zero and every output is low. With zero steering bytes, each line resolves to core 0, pin 0.
- R2: The pin of line i comes from byte i/32 of the pin table, which is word 8, byte n at bits 8n+7..8n. In one-hot mode the pin is the index of the lowest set bit of that byte. A zero byte, or a lowest set bit at index 4 or above, gives pin 0.
- R3: The core of line i comes from byte i%8 of core-table word 32+i/8. In one-hot mode the core is the index of the lowest set bit. A zero byte, or an index of 4 or above, gives core 0.
- R4: Configuration bit 1 selects binary pin decoding and bit 2 selects binary core decoding. In binary mode the byte value is the pin or core number, and a value of 4 or above gives 0.
- R5: Raw-level words 4 to 7 hold each line's input level, registered one cycle, with line i at word 4+i/64, bit i%64. A rising input on a line whose enable bit is clear still updates this level, but creates no pending bit and no output.
- R6: Output bit c*4+p rises one clock after the first pending line steered to core c, pin p appears. It falls one clock after the last such line stops pending.
- R7: A falling input clears the line's pending bit.
- R8: The pending view uses words 16 to 19, with line i at bit i%64 of word 16+i/64. Only lines pending on the core named by the core selector are shown. Writing ones there clears those lines for that core only. Lines pending on other cores are unaffected.
- R9: The enable bits are in words 0 to 3, laid out like the raw-level words. Setting an enable bit while the input is high makes the line pending. Clearing it withdraws the line's pending bit.
- R10: Suppose a core-table write changes a line's decoded core while that line's input is high. The line then leaves its old core and becomes pending on the new one, provided it is enabled. This also re-raises a line that was cleared by software.
- R11: The configuration is word 9, bit 0 being controller enable. The capability word is word 10 and is read-only, with a default of 0x07. A written value is ANDed with the capability word. A nonzero write is discarded while bit 0 is set, but a zero write is always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 256 | Device interrupt levels, one per line |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register word address |
| regWdata | input | 64 | Register write data |
| regCore | input | 2 | Core whose pending view is read or cleared |
| regRdata | output | 64 | Register read data, combinational on the address |
| coreIrq | output | 16 | Per core/pin interrupt outputs, bit core*4+pin |

## Verification
Four properties are checked on every cycle:
- no line is pending unless it is both enabled and currently high;
- the outputs follow the presence or absence of pending lines one clock later;
- the raw levels track the inputs;
- the configuration never holds a bit outside the capability word and stays frozen under a locked nonzero write.

The exact output bit chosen by each steering byte needs the bench's scenarios to show:
- one-hot and binary decoding with their fallbacks;
- per-core clearing that leaves other cores alone;
- migration and re-raise on a core change;
- enable withdrawal.

A behavioural model in the bench also compares all sixteen outputs on every clock.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 64;
  localparam int SEL_W = 8;

  // word address bases
  localparam int A_ENABLE = 0;
  localparam int A_RAW = 4;
  localparam int A_PINMAP = 8;
  localparam int A_CONFIG = 9;
  localparam int A_FEATURE = 10;
  localparam int A_PEND = 16;
  localparam int A_COREMAP = 32;

  // configuration bit positions
  localparam int CFG_ON = 0;
  localparam int CFG_PIN_BIN = 1;
  localparam int CFG_CORE_BIN = 2;

  typedef enum logic [2:0] {
    RD_NONE, RD_ENABLE, RD_RAW, RD_PINMAP, RD_CONFIG, RD_FEATURE, RD_PEND, RD_COREMAP
  } rdSel_e;

  typedef struct packed {
    logic enWe;
    logic pinWe;
    logic cfgWe;
    logic clrWe;
    logic mapWe;
    logic [4:0] idx;
    rdSel_e rdSel;
  } ctrlStrobe_t;

  // steering byte to index; out-of-range results fall back to zero
  function automatic int unsigned decodeSel(input logic [SEL_W-1:0] sel, input logic binary,
                                            input int unsigned limit);
    int unsigned r;
    if (binary) begin
      r = 32'(sel);
    end else begin
      r = limit;
      for (int b = SEL_W - 1; b >= 0; b--) begin
        if (sel[b]) r = 32'(b);
      end
    end
    return (r < limit) ? r : 0;
  endfunction
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 256
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  input  logic              cfgOn,
  output ctrlStrobe_t       strb
);
  localparam int EN_WORDS = NUM_IRQ / WORD_W;
  localparam int MAP_WORDS = NUM_IRQ / SEL_W;

  int addrInt;

  function automatic logic inWin(input int a, input int base, input int n);
    return (a >= base) && (a < base + n);
  endfunction

  always_comb begin
    addrInt = int'(regAddr);
    strb = '0;
    if (inWin(addrInt, A_ENABLE, EN_WORDS)) begin
      strb.rdSel = RD_ENABLE;
      strb.enWe = regWe;
      strb.idx = 5'(addrInt - A_ENABLE);
    end else if (inWin(addrInt, A_RAW, EN_WORDS)) begin
      strb.rdSel = RD_RAW;
      strb.idx = 5'(addrInt - A_RAW);
    end else if (addrInt == A_PINMAP) begin
      strb.rdSel = RD_PINMAP;
      strb.pinWe = regWe;
    end else if (addrInt == A_CONFIG) begin
      strb.rdSel = RD_CONFIG;
      // locked: only a zero value passes while the controller is on
      strb.cfgWe = regWe && !(cfgOn && (regWdata != '0));
    end else if (addrInt == A_FEATURE) begin
      strb.rdSel = RD_FEATURE;
    end else if (inWin(addrInt, A_PEND, EN_WORDS)) begin
      strb.rdSel = RD_PEND;
      strb.clrWe = regWe;
      strb.idx = 5'(addrInt - A_PEND);
    end else if (inWin(addrInt, A_COREMAP, MAP_WORDS)) begin
      strb.rdSel = RD_COREMAP;
      strb.mapWe = regWe;
      strb.idx = 5'(addrInt - A_COREMAP);
    end
  end
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 256,
  parameter int NUM_CORE = 4,
  parameter int NUM_PIN = 4,
  parameter logic [7:0] FEATURES = 8'h07,
  localparam int CORE_W = $clog2(NUM_CORE),
  localparam int OUT_N = NUM_CORE * NUM_PIN
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  ctrlStrobe_t        strb,
  input  logic [WORD_W-1:0]  regWdata,
  input  logic [CORE_W-1:0]  regCore,
  output logic [WORD_W-1:0]  regRdata,
  output logic [OUT_N-1:0]   coreIrq,
  output logic               cfgOn,
  output logic [NUM_IRQ-1:0] pendBits,
  output logic [NUM_IRQ-1:0] rawBits,
  output logic [NUM_IRQ-1:0] enBits,
  output logic [7:0]         cfgBits
);
  localparam int EN_WORDS = NUM_IRQ / WORD_W;
  localparam int MAP_WORDS = NUM_IRQ / SEL_W;
  localparam int GROUP = 32;
  localparam int GROUPS = NUM_IRQ / GROUP;
  localparam int PIN_W = $clog2(NUM_PIN);

  logic [NUM_IRQ-1:0] enReg, rawReg, pendReg, enNext, pendNext;
  logic [NUM_IRQ-1:0] clrHit, remap, lower, raise;
  logic [GROUPS*SEL_W-1:0] pinMap;
  logic [7:0] cfgReg;
  logic [SEL_W-1:0] coreMap [NUM_IRQ];
  logic [SEL_W-1:0] mapByteNew [NUM_IRQ];
  logic [CORE_W-1:0] routeCore [NUM_IRQ];
  logic [CORE_W-1:0] newCore [NUM_IRQ];
  logic [PIN_W-1:0] routePin [NUM_IRQ];
  logic [OUT_N-1:0] hitNext;

  // per-line routing and pending next state
  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      routePin[i] = PIN_W'(decodeSel(pinMap[(i / GROUP) * SEL_W +: SEL_W], cfgReg[CFG_PIN_BIN],
                                     NUM_PIN));
      routeCore[i] = CORE_W'(decodeSel(coreMap[i], cfgReg[CFG_CORE_BIN], NUM_CORE));
      mapByteNew[i] = (strb.mapWe && strb.idx == 5'(i / SEL_W))
                      ? regWdata[(i % SEL_W) * SEL_W +: SEL_W] : coreMap[i];
      newCore[i] = CORE_W'(decodeSel(mapByteNew[i], cfgReg[CFG_CORE_BIN], NUM_CORE));
      enNext[i] = (strb.enWe && strb.idx == 5'(i / WORD_W)) ? regWdata[i % WORD_W] : enReg[i];
      clrHit[i] = strb.clrWe && (strb.idx == 5'(i / WORD_W)) && regWdata[i % WORD_W]
                  && (routeCore[i] == regCore);
      remap[i] = (newCore[i] != routeCore[i]) && rawReg[i];
      lower[i] = (rawReg[i] & ~irqIn[i]) | clrHit[i] | (enReg[i] & ~enNext[i] & rawReg[i]);
      raise[i] = enNext[i] & irqIn[i] & (~rawReg[i] | ~enReg[i] | remap[i]);
      pendNext[i] = (pendReg[i] & ~lower[i]) | raise[i];
    end
  end

  // OR of pending lines onto their core/pin pair
  always_comb begin
    hitNext = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pendReg[i]) hitNext[int'(routeCore[i]) * NUM_PIN + int'(routePin[i])] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= '0;
      rawReg <= '0;
      pendReg <= '0;
      pinMap <= '0;
      cfgReg <= '0;
      coreIrq <= '0;
      for (int i = 0; i < NUM_IRQ; i++) coreMap[i] <= '0;
    end else begin
      enReg <= enNext;
      rawReg <= irqIn;
      pendReg <= pendNext;
      coreIrq <= hitNext;
      if (strb.pinWe) pinMap <= regWdata[GROUPS*SEL_W-1:0];
      if (strb.cfgWe) cfgReg <= regWdata[7:0] & FEATURES;
      for (int i = 0; i < NUM_IRQ; i++) coreMap[i] <= mapByteNew[i];
    end
  end

  // read mux
  always_comb begin
    regRdata = '0;
    case (strb.rdSel)
      RD_ENABLE: begin
        for (int w = 0; w < EN_WORDS; w++)
          if (strb.idx == 5'(w)) regRdata = enReg[w*WORD_W +: WORD_W];
      end
      RD_RAW: begin
        for (int w = 0; w < EN_WORDS; w++)
          if (strb.idx == 5'(w)) regRdata = rawReg[w*WORD_W +: WORD_W];
      end
      RD_PEND: begin
        for (int w = 0; w < EN_WORDS; w++)
          if (strb.idx == 5'(w))
            for (int b = 0; b < WORD_W; b++)
              regRdata[b] = pendReg[w*WORD_W + b] && (routeCore[w*WORD_W + b] == regCore);
      end
      RD_PINMAP: regRdata[GROUPS*SEL_W-1:0] = pinMap;
      RD_CONFIG: regRdata[7:0] = cfgReg;
      RD_FEATURE: regRdata[7:0] = FEATURES;
      RD_COREMAP: begin
        for (int w = 0; w < MAP_WORDS; w++)
          if (strb.idx == 5'(w))
            for (int b = 0; b < WORD_W / SEL_W; b++)
              regRdata[b*SEL_W +: SEL_W] = coreMap[w*(WORD_W/SEL_W) + b];
      end
      default: regRdata = '0;
    endcase
  end

  assign cfgOn = cfgReg[CFG_ON];
  assign pendBits = pendReg;
  assign rawBits = rawReg;
  assign enBits = enReg;
  assign cfgBits = cfgReg;
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 256,
  parameter int NUM_CORE = 4,
  parameter int NUM_PIN = 4,
  parameter logic [7:0] FEATURES = 8'h07,
  localparam int CORE_W = $clog2(NUM_CORE),
  localparam int OUT_N = NUM_CORE * NUM_PIN
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [WORD_W-1:0]  regWdata,
  input  logic [CORE_W-1:0]  regCore,
  output logic [WORD_W-1:0]  regRdata,
  output logic [OUT_N-1:0]   coreIrq
);
  ctrlStrobe_t strb;
  logic cfgOn;
  logic [NUM_IRQ-1:0] pendBits, rawBits, enBits;
  logic [7:0] cfgBits;

  irq_route_ctrl #(.NUM_IRQ(NUM_IRQ)) i_ctrl (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .cfgOn(cfgOn), .strb(strb)
  );

  irq_route_dp #(
    .NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN), .FEATURES(FEATURES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strb(strb), .regWdata(regWdata),
    .regCore(regCore), .regRdata(regRdata), .coreIrq(coreIrq), .cfgOn(cfgOn),
    .pendBits(pendBits), .rawBits(rawBits), .enBits(enBits), .cfgBits(cfgBits)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 256,
  parameter int OUT_N = 16,
  parameter logic [7:0] FEATURES = 8'h07
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_IRQ-1:0] irqIn,
  input logic               regWe,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [WORD_W-1:0]  regWdata,
  input logic [OUT_N-1:0]   coreIrq,
  input logic [NUM_IRQ-1:0] pendBits,
  input logic [NUM_IRQ-1:0] rawBits,
  input logic [NUM_IRQ-1:0] enBits,
  input logic [7:0]         cfgBits
);
  assert_pend_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pendBits & ~(rawBits & enBits)) == '0);

  assert_raw_track_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (rawBits == $past(irqIn)));

  assert_out_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|pendBits) |=> (|coreIrq));

  assert_out_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(|pendBits) |=> (coreIrq == '0));

  assert_cfg_masked_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBits & ~FEATURES) == 8'h00);

  assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(A_CONFIG) && regWdata != '0 && cfgBits[CFG_ON])
      |=> $stable(cfgBits));
endmodule

bind irq_route_top irq_route_chk #(
  .NUM_IRQ(NUM_IRQ), .OUT_N(OUT_N), .FEATURES(FEATURES)
) i_chk (
  .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .coreIrq(coreIrq), .pendBits(pendBits), .rawBits(rawBits),
  .enBits(enBits), .cfgBits(cfgBits)
);

// File: tb/test_irq_route_top.sv
`timescale 1ns/1ps
module test_irq_route_top;
  localparam int NI = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NI-1:0] irqIn = '0;
  logic regWe = 1'b0;
  logic [5:0] regAddr = '0;
  logic [63:0] regWdata = '0;
  logic [1:0] regCore = '0;
  logic [63:0] regRdata;
  logic [15:0] coreIrq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_route_top i_irq_route_top (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regCore(regCore), .regRdata(regRdata), .coreIrq(coreIrq)
  );

  // behavioural reference state
  bit mEn [NI];
  bit mRaw [NI];
  bit mPend [NI];
  int mCmap [NI];
  int mPin [8];
  int mCfg;
  logic [15:0] mOut;

  function automatic int pick(input int sel, input bit bin, input int lim);
    int r;
    if (bin) r = sel;
    else begin
      r = lim;
      for (int b = 0; b < 8; b++) if (sel[b] && r == lim) r = b;
    end
    return (r < lim) ? r : 0;
  endfunction

  function automatic int coreOf(input int byteVal);
    return pick(byteVal, mCfg[2], 4);
  endfunction

  task automatic modelStep();
    logic [15:0] o;
    int a;
    bit nEn [NI];
    int nMap [NI];
    bit inLv, fall, clr, dis, ena, mv, lw, rs;
    o = '0;
    for (int i = 0; i < NI; i++)
      if (mPend[i]) o[coreOf(mCmap[i]) * 4 + pick(mPin[i / 32], mCfg[1], 4)] = 1'b1;
    a = int'(regAddr);
    for (int i = 0; i < NI; i++) begin
      nEn[i] = mEn[i];
      nMap[i] = mCmap[i];
      if (regWe && a == i / 64) nEn[i] = regWdata[i % 64];
      if (regWe && a == 32 + i / 8) nMap[i] = int'(regWdata[(i % 8) * 8 +: 8]);
    end
    for (int i = 0; i < NI; i++) begin
      inLv = irqIn[i];
      fall = mRaw[i] && !inLv;
      clr = regWe && a == 16 + i / 64 && regWdata[i % 64] && coreOf(mCmap[i]) == int'(regCore);
      dis = mEn[i] && !nEn[i] && mRaw[i];
      ena = nEn[i] && !mEn[i];
      mv = mRaw[i] && coreOf(nMap[i]) != coreOf(mCmap[i]);
      lw = fall || clr || dis;
      rs = nEn[i] && inLv && (!mRaw[i] || ena || mv);
      mPend[i] = (mPend[i] && !lw) || rs;
      mRaw[i] = inLv;
      mEn[i] = nEn[i];
      mCmap[i] = nMap[i];
    end
    if (regWe && a == 8) for (int g = 0; g < 8; g++) mPin[g] = int'(regWdata[g*8 +: 8]);
    if (regWe && a == 9 && !(mCfg[0] && regWdata != 0)) mCfg = int'(regWdata[7:0]) & 32'h07;
    mOut = o;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NI; i++) begin
        mEn[i] = 0; mRaw[i] = 0; mPend[i] = 0; mCmap[i] = 0;
      end
      for (int g = 0; g < 8; g++) mPin[g] = 0;
      mCfg = 0;
      mOut = '0;
    end else begin
      modelStep();
    end
  end

  // per-clock comparison of the outputs against the model (R6)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      total++;
      if (coreIrq !== mOut) begin
        bad++;
        $display("FAIL R6 model compare: coreIrq=%h expected=%h at %0t", coreIrq, mOut, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [63:0] d, input int c);
    regWe = 1'b1; regAddr = 6'(a); regWdata = d; regCore = 2'(c);
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input int a, input int c, output logic [63:0] d);
    regAddr = 6'(a); regCore = 2'(c);
    #1;
    d = regRdata;
  endtask

  task automatic setIrq(input int i, input logic v);
    irqIn[i] = v;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", 64'(coreIrq), 64'h0);
    rd(0, 0, d); chk("R1 enable word", d, 64'h0);
    rd(9, 0, d); chk("R1 config", d, 64'h0);
    rd(32, 0, d); chk("R1 core table", d, 64'h0);

    // R5 disabled line records level only
    setIrq(5, 1'b1);
    @(negedge clk);
    rd(4, 0, d); chk("R5 raw level", d, 64'h20);
    chk("R5 no output", 64'(coreIrq), 64'h0);
    rd(16, 0, d); chk("R5 no pending", d, 64'h0);

    // R9 enabling a high line delivers it, R1 default route core0 pin0
    wr(0, 64'h20, 0);
    @(negedge clk);
    chk("R9 enable delivers", 64'(coreIrq), 64'h1);
    rd(16, 0, d); chk("R8 pending view core0", d, 64'h20);

    // R7 fall clears
    setIrq(5, 1'b0);
    @(negedge clk);
    chk("R7 fall clears", 64'(coreIrq), 64'h0);

    // R2/R3 one-hot steering, R6 aggregation
    wr(8, 64'h0400, 0);
    wr(37, 64'h0202, 0);
    wr(0, (64'h1 << 40) | (64'h1 << 41), 0);
    setIrq(40, 1'b1);
    @(negedge clk);
    chk("R2 R3 core1 pin2", 64'(coreIrq), 64'h0040);
    setIrq(41, 1'b1);
    setIrq(40, 1'b0);
    @(negedge clk);
    chk("R6 held by second line", 64'(coreIrq), 64'h0040);
    setIrq(41, 1'b0);
    @(negedge clk);
    chk("R6 last clear drops", 64'(coreIrq), 64'h0);

    // R2/R3 one-hot fallbacks
    wr(8, 64'h1000, 0);
    wr(37, 64'h30, 0);
    setIrq(40, 1'b1);
    @(negedge clk);
    chk("R2 R3 fallback core0 pin0", 64'(coreIrq), 64'h1);
    setIrq(40, 1'b0);
    @(negedge clk);

    // R8 per-core clear
    wr(40, 64'h0004_0000_0000_0000, 0);
    wr(1, 64'h40, 0);
    setIrq(70, 1'b1);
    @(negedge clk);
    chk("R3 line70 core2", 64'(coreIrq), 64'h0100);
    rd(17, 2, d); chk("R8 view core2", d, 64'h40);
    rd(17, 1, d); chk("R8 view core1", d, 64'h0);
    wr(17, 64'h40, 1);
    @(negedge clk);
    chk("R8 other core clear ignored", 64'(coreIrq), 64'h0100);
    wr(17, 64'h40, 2);
    @(negedge clk);
    chk("R8 clear own core", 64'(coreIrq), 64'h0);
    rd(17, 2, d); chk("R8 view after clear", d, 64'h0);

    // R10 migration re-raises on new core
    wr(40, 64'h0008_0000_0000_0000, 0);
    @(negedge clk);
    chk("R10 migrate to core3", 64'(coreIrq), 64'h1000);
    rd(17, 3, d); chk("R10 view core3", d, 64'h40);

    // R9 withdraw and re-enable
    wr(1, 64'h0, 0);
    @(negedge clk);
    chk("R9 disable withdraws", 64'(coreIrq), 64'h0);
    rd(5, 0, d); chk("R5 raw kept", d, 64'h40);
    wr(1, 64'h40, 0);
    @(negedge clk);
    chk("R9 re-enable", 64'(coreIrq), 64'h1000);
    setIrq(70, 1'b0);
    @(negedge clk);

    // R11 configuration masking and lock
    rd(10, 0, d); chk("R11 capability", d, 64'h07);
    wr(9, 64'hFF, 0);
    rd(9, 0, d); chk("R11 masked write", d, 64'h07);
    wr(9, 64'h02, 0);
    rd(9, 0, d); chk("R11 locked write", d, 64'h07);
    wr(9, 64'h0, 0);
    rd(9, 0, d); chk("R11 zero write", d, 64'h0);
    wr(9, 64'h06, 0);
    rd(9, 0, d); chk("R11 binary modes", d, 64'h06);

    // R4 binary decoding
    wr(8, 64'h0300_0000, 0);
    wr(44, 64'h0000_0002_0000_0000, 0);
    wr(1, 64'h1 << 36, 0);
    setIrq(100, 1'b1);
    @(negedge clk);
    chk("R4 binary core2 pin3", 64'(coreIrq), 64'h0800);
    wr(44, 64'h0000_0007_0000_0000, 0);
    @(negedge clk);
    chk("R4 binary fallback core0", 64'(coreIrq), 64'h0008);
    setIrq(100, 1'b0);
    @(negedge clk);
    chk("R7 final clear", 64'(coreIrq), 64'h0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule